// File: doc/BRIEF.md
# Paged Window Address Map

This block sits on a 16-bit host bus and turns host accesses that land in a fixed upper address window into 32-bit accesses on a secondary bus. The window is cut into a small number of equal pages. Each page is steered through an entry in a page table. An entry holds a secondary-bus page number and two permission flags: one says the entry may be used at all, the other says it may be written through. The table itself is exposed as a run of 16-bit host registers, so software loads it with ordinary host writes and can read it back.

Each host page covers 256 secondary-bus words. A 32-bit secondary word appears to the host as two 16-bit halves at consecutive even byte addresses. A low-half write is held in a buffer, and the secondary write goes out when the high half arrives. A low-half read fetches the whole word, returns its lower half and keeps the upper half, which a following high-half read returns without touching the secondary bus. An access through an unusable entry, or a write through a read-only entry, is refused. The block then acknowledges it with a map-error flag and makes no secondary-bus request.

The host side uses a one-cycle strobe, and the block answers with a one-cycle acknowledge. The secondary side uses a request that is held until a one-cycle acknowledge. Host addresses that fall in neither the table registers nor the window are not claimed.

Top module: `pw_addr_map`

## Requirements
- R1: After synchronous active-low reset, h_ack, h_maperr and s_req are low, h_rdata is zero and every table entry is zero, so every window access is refused until the table is loaded.
- R2: Table entry n is the 16-bit host register at byte address REG_BASE + 0o140 + 2n (default REG_BASE 0o766000). A write stores all 16 bits and a read returns them, each acknowledged on the cycle after the strobe with h_maperr low.
- R3: Entry fields are bit 15 = usable, bit 14 = writable, and bits 13..0 = secondary page number.
- R4: The window is host byte addresses 0o140000 to 0o177777. The page index is (address - 0o140000) / 1024.
- R5: The secondary word address is page_number * 256 + (host address bits 9..2).
- R6: A permitted write with address bit 1 = 0 (low half) is buffered, acknowledged on the next cycle and makes no secondary request.
- R7: A permitted write with address bit 1 = 1 (high half) raises s_req with s_we high on the next cycle and s_wdata = {host data, buffered low half}. h_ack follows one cycle after the cycle in which s_ack is high.
- R8: A permitted read of a low half raises s_req with s_we low. One cycle after s_ack it acknowledges with h_rdata = s_rdata[15:0] and keeps s_rdata[31:16].
- R9: A permitted read of a high half is acknowledged on the next cycle with the kept upper half and makes no secondary request.
- R10: An access through an entry with bit 15 clear is acknowledged on the next cycle with h_maperr high and no secondary request.
- R11: A write through an entry with bit 14 clear is refused as in R10 and changes neither the buffer nor the secondary memory; reads through it proceed.
- R12: A strobe outside both the table registers and the window gives no h_ack and no s_req.
- R13: While s_req is high and s_ack is low, s_req, s_we, s_addr and s_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_stb | input | 1 | One-cycle host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | HA_W (18) | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_ack | output | 1 | One-cycle host acknowledge |
| h_rdata | output | 16 | Host read data, valid with h_ack |
| h_maperr | output | 1 | Refused access, valid with h_ack |
| s_req | output | 1 | Secondary request, held until s_ack |
| s_we | output | 1 | Secondary write (1) or read (0) |
| s_addr | output | 14+WOFF_W (22) | Secondary word address |
| s_wdata | output | 32 | Secondary write data |
| s_ack | input | 1 | One-cycle secondary acknowledge |
| s_rdata | input | 32 | Secondary read data, valid with s_ack |

## Verification
The bench aims at the half-word pairing. It writes a high half with no fresh low half, reads a high half long after the low-half read, and checks that a refused low write leaves the buffer alone. A design that forwarded each half or refreshed the buffer on a refused write would show the wrong s_wdata. It also checks the page boundaries at the window's ends and the last word of a page. An off-by-one page index or a dropped offset bit would put out a wrong s_addr. Read-only entries get both reads and writes, and random secondary latencies test that the request holds until it is acknowledged.

// File: rtl/pw_map_pkg.sv
// Package: shared entry layout for the paged window address map.
// Assumes the 16-bit entry format: usable, writable, 14-bit page number.
package pw_map_pkg;
    localparam int ENT_W = 16;
    localparam int PG_W  = 14;

    typedef struct packed {
        logic            usable;
        logic            writable;
        logic [PG_W-1:0] page;
    } map_ent_t;
endpackage

// File: rtl/pw_map_table.sv
// Module: page table storage with one host read/write port and one
// translation lookup port. Assumes the caller only writes while idle.
module pw_map_table
    import pw_map_pkg::*;
#(
    parameter int N_PAGES = 16,
    localparam int IDX_W  = $clog2(N_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [ENT_W-1:0] wr_data,
    output logic [ENT_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0] xl_idx,
    output map_ent_t         xl_ent
);
    map_ent_t ents [N_PAGES];

    // One register per entry, cleared on reset, loaded on a host write.
    for (genvar g = 0; g < N_PAGES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ents[g] <= '0;
            else if (wr_en && reg_idx == IDX_W'(g))
                ents[g] <= map_ent_t'(wr_data);
        end
    end

    // Host register read and translation lookup.
    always_comb begin
        reg_rdata = ENT_W'(ents[reg_idx]);
        xl_ent    = ents[xl_idx];
    end

    // R2: a host table write lands in the addressed entry.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ENT_W'(ents[$past(reg_idx)]) == $past(wr_data));
endmodule

// File: rtl/pw_map_xlate.sv
// Module: decodes a host address into table-register hit or window hit,
// forms the secondary word address and decides refusal.
// Assumes REG_BASE+0o140 and WIN_BASE are aligned to their region sizes.
module pw_map_xlate
    import pw_map_pkg::*;
#(
    parameter int          N_PAGES  = 16,
    parameter int          WOFF_W   = 8,
    parameter int          HA_W     = 18,
    parameter logic [17:0] REG_BASE = 18'o766000,
    parameter logic [17:0] WIN_BASE = 18'o140000,
    localparam int IDX_W  = $clog2(N_PAGES),
    localparam int SA_W   = PG_W + WOFF_W
) (
    input  logic             is_wr,
    input  logic [HA_W-1:0]  haddr,
    input  map_ent_t         ent,
    output logic             in_tbl,
    output logic             in_win,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [IDX_W-1:0] pg_idx,
    output logic             hi_half,
    output logic [SA_W-1:0]  word_addr,
    output logic             refuse
);
    localparam logic [HA_W-1:0] TBL_LO  = HA_W'(REG_BASE) + HA_W'(18'o140);
    localparam logic [HA_W-1:0] WIN_LO  = HA_W'(WIN_BASE);
    localparam int              PG_BITS = WOFF_W + 2;
    localparam int              WIN_SZ  = N_PAGES << PG_BITS;

    logic [HA_W-1:0] tbl_off, win_off;

    // Region decode, index extraction and address formation.
    always_comb begin
        tbl_off   = haddr - TBL_LO;
        win_off   = haddr - WIN_LO;
        in_tbl    = (haddr >= TBL_LO) && (tbl_off < HA_W'(2 * N_PAGES));
        in_win    = (haddr >= WIN_LO) && (win_off < HA_W'(WIN_SZ));
        tbl_idx   = tbl_off[IDX_W:1];
        pg_idx    = win_off[PG_BITS +: IDX_W];
        hi_half   = haddr[1];
        word_addr = {ent.page, haddr[PG_BITS-1:2]};
        refuse    = !ent.usable || (is_wr && !ent.writable);
    end

    // R4: the two decoded regions never overlap.
    always_comb begin
        a_r4_disjoint: assert (!(in_tbl && in_win));
    end
endmodule

// File: rtl/pw_map_steer.sv
// Module: half-word steering store: the buffered low half of a pending
// write and the kept upper half of the last secondary read.
module pw_map_steer #(
    parameter int HD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_we,
    input  logic [HD_W-1:0]   low_d,
    input  logic              rd_cap,
    input  logic [2*HD_W-1:0] rd_d,
    input  logic [HD_W-1:0]   hi_wr,
    output logic [2*HD_W-1:0] wr_word,
    output logic [HD_W-1:0]   hi_q
);
    logic [HD_W-1:0] low_q;

    // Hold the low half until its high half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_q <= '0;
        else if (low_we) low_q <= low_d;
    end

    // Keep the upper half of each completed secondary read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (rd_cap) hi_q <= rd_d[2*HD_W-1:HD_W];
    end

    // Assemble the outgoing 32-bit word.
    always_comb wr_word = {hi_wr, low_q};

    // R6: the buffer changes only on a permitted low-half write.
    a_r6_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !low_we |=> $stable(low_q));
    // R9: the kept upper half changes only on a completed read.
    a_r9_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cap |=> $stable(hi_q));
endmodule

// File: rtl/pw_addr_map.sv
// Module: top of the paged window address map. Sequences host accesses
// through the table, the translator and the half-word store.
// Assumes the host strobes again only after h_ack, and s_ack comes only
// while s_req is high.
module pw_addr_map
    import pw_map_pkg::*;
#(
    parameter int          N_PAGES  = 16,
    parameter int          WOFF_W   = 8,
    parameter int          HA_W     = 18,
    parameter logic [17:0] REG_BASE = 18'o766000,
    parameter logic [17:0] WIN_BASE = 18'o140000,
    localparam int HD_W  = 16,
    localparam int SA_W  = PG_W + WOFF_W,
    localparam int IDX_W = $clog2(N_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_stb,
    input  logic              h_we,
    input  logic [HA_W-1:0]   h_addr,
    input  logic [HD_W-1:0]   h_wdata,
    output logic              h_ack,
    output logic [HD_W-1:0]   h_rdata,
    output logic              h_maperr,
    output logic              s_req,
    output logic              s_we,
    output logic [SA_W-1:0]   s_addr,
    output logic [2*HD_W-1:0] s_wdata,
    input  logic              s_ack,
    input  logic [2*HD_W-1:0] s_rdata
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_t;
    st_t st_q;

    logic             in_tbl, in_win, hi_half, refuse;
    logic [IDX_W-1:0] tbl_idx, pg_idx;
    logic [SA_W-1:0]  word_addr;
    logic [ENT_W-1:0] tbl_rdata;
    map_ent_t         ent;
    logic [2*HD_W-1:0] wr_word;
    logic [HD_W-1:0]  hi_q;
    logic             take, tbl_wr, low_we, rd_cap, win_ok;

    pw_map_xlate #(
        .N_PAGES(N_PAGES), .WOFF_W(WOFF_W), .HA_W(HA_W),
        .REG_BASE(REG_BASE), .WIN_BASE(WIN_BASE)
    ) u_xlate (
        .is_wr(h_we), .haddr(h_addr), .ent(ent),
        .in_tbl(in_tbl), .in_win(in_win), .tbl_idx(tbl_idx),
        .pg_idx(pg_idx), .hi_half(hi_half), .word_addr(word_addr),
        .refuse(refuse)
    );

    pw_map_table #(.N_PAGES(N_PAGES)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .reg_idx(tbl_idx),
        .wr_data(h_wdata), .reg_rdata(tbl_rdata), .xl_idx(pg_idx),
        .xl_ent(ent)
    );

    pw_map_steer #(.HD_W(HD_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .low_we(low_we), .low_d(h_wdata),
        .rd_cap(rd_cap), .rd_d(s_rdata), .hi_wr(h_wdata),
        .wr_word(wr_word), .hi_q(hi_q)
    );

    // Enables derived from the accepted strobe.
    always_comb begin
        take   = h_stb && st_q == ST_IDLE;
        win_ok = take && in_win && !refuse;
        tbl_wr = take && in_tbl && h_we;
        low_we = win_ok && h_we && !hi_half;
        rd_cap = st_q == ST_WAIT && s_ack && !s_we;
    end

    // Access sequencer: answers locally or issues one secondary request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            h_ack    <= 1'b0;
            h_maperr <= 1'b0;
            h_rdata  <= '0;
            s_req    <= 1'b0;
            s_we     <= 1'b0;
            s_addr   <= '0;
            s_wdata  <= '0;
        end else begin
            h_ack    <= 1'b0;
            h_maperr <= 1'b0;
            if (st_q == ST_WAIT) begin
                if (s_ack) begin
                    s_req <= 1'b0;
                    h_ack <= 1'b1;
                    st_q  <= ST_IDLE;
                    if (!s_we) h_rdata <= s_rdata[HD_W-1:0];
                end
            end else if (take && in_tbl) begin
                h_ack <= 1'b1;
                if (!h_we) h_rdata <= tbl_rdata;
            end else if (take && in_win) begin
                if (refuse) begin
                    h_ack    <= 1'b1;
                    h_maperr <= 1'b1;
                end else if (h_we && !hi_half) begin
                    h_ack <= 1'b1;
                end else if (!h_we && hi_half) begin
                    h_ack   <= 1'b1;
                    h_rdata <= hi_q;
                end else begin
                    s_req  <= 1'b1;
                    s_we   <= h_we;
                    s_addr <= word_addr;
                    if (h_we) s_wdata <= wr_word;
                    st_q   <= ST_WAIT;
                end
            end
        end
    end

    // R13: an unacknowledged request holds everything it carries.
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_req && !s_ack |=> s_req && $stable(s_we) && $stable(s_addr)
                            && $stable(s_wdata));
    // R10: a map error is only ever reported with an acknowledge.
    a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        h_maperr |-> h_ack && !s_req);
    // R7: a new request always follows an accepted host strobe.
    a_r7_req_from_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_req) |-> $past(h_stb));
    // R2: acknowledges are single-cycle pulses.
    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |=> !h_ack);
endmodule

// File: tb/sim_pw_addr_map.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks with hand-computed values.
module sim_pw_addr_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_stb = 1'b0, h_we = 1'b0;
    logic [17:0] h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic        h_ack, h_maperr, s_req, s_we;
    logic [15:0] h_rdata;
    logic [21:0] s_addr;
    logic [31:0] s_wdata;
    logic        s_ack = 1'b0;
    logic [31:0] s_rdata = '0;

    int checks = 0, errors = 0, cyc = 0;

    pw_addr_map u0 (
        .clk(clk), .rst_n(rst_n), .h_stb(h_stb), .h_we(h_we),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_ack(h_ack),
        .h_rdata(h_rdata), .h_maperr(h_maperr), .s_req(s_req),
        .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ack(s_ack), .s_rdata(s_rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    // Secondary memory: written words, else an address-derived pattern.
    logic [31:0] mem [int];
    function automatic logic [31:0] mem_rd(input logic [21:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {a[15:0] ^ 16'h5a5a, ~a[15:0]};
    endfunction

    // Secondary responder with address-dependent latency.
    int lat = 0;
    always @(negedge clk) begin
        if (s_ack) begin
            s_ack = 1'b0;
            lat   = 0;
        end else if (s_req && rst_n) begin
            lat++;
            if (lat > int'(s_addr % 4)) begin
                s_ack = 1'b1;
                if (s_we) mem[int'(s_addr)] = s_wdata;
                else      s_rdata = mem_rd(s_addr);
            end
        end
    end

    // Reference model state and expected outputs.
    logic [15:0] m_tbl [16];
    logic [15:0] m_low, m_hi;
    bit          m_busy;
    bit          e_ack, e_err, e_req, e_we, e_rdchk;
    logic [15:0] e_rd;
    logic [21:0] e_addr;
    logic [31:0] e_wd;
    string       m_tag = "R1";

    localparam logic [17:0] TBL = 18'o766140;
    localparam logic [17:0] WLO = 18'o140000;

    always @(posedge clk) begin
        e_ack = 0;
        e_err = 0;
        if (!rst_n) begin
            foreach (m_tbl[i]) m_tbl[i] = '0;
            m_low = '0; m_hi = '0; m_busy = 0;
            e_req = 0; e_we = 0; e_rdchk = 0; e_rd = '0; m_tag = "R1";
        end else if (m_busy) begin
            if (s_ack) begin
                e_req = 0; e_ack = 1; m_busy = 0;
                if (!e_we) begin
                    m_hi = s_rdata[31:16];
                    e_rd = s_rdata[15:0];
                    e_rdchk = 1;
                end
            end
        end else if (h_stb) begin
            e_rdchk = 0;
            if (h_addr >= TBL && h_addr < TBL + 32) begin
                m_tag = "R2";
                e_ack = 1;
                if (h_we) m_tbl[(h_addr - TBL) / 2] = h_wdata;
                else begin
                    e_rd = m_tbl[(h_addr - TBL) / 2];
                    e_rdchk = 1;
                end
            end else if (h_addr >= WLO && h_addr <= 18'o177777) begin
                logic [15:0] ent;
                ent = m_tbl[(h_addr - WLO) / 1024];
                if (!ent[15] || (h_we && !ent[14])) begin
                    m_tag = ent[15] ? "R11" : "R10";
                    e_ack = 1; e_err = 1;
                end else if (h_we && !h_addr[1]) begin
                    m_tag = "R6"; e_ack = 1; m_low = h_wdata;
                end else if (!h_we && h_addr[1]) begin
                    m_tag = "R9"; e_ack = 1; e_rd = m_hi; e_rdchk = 1;
                end else begin
                    m_tag = h_we ? "R7" : "R8";
                    m_busy = 1; e_req = 1; e_we = h_we;
                    e_addr = 22'(ent[13:0]) * 256 + 22'(h_addr[9:2]);
                    if (h_we) e_wd = {h_wdata, m_low};
                end
            end else begin
                m_tag = "R12";
            end
        end
    end

    // Compare registered outputs with the model every cycle.
    always @(negedge clk) begin
        if (cyc > 0) begin
            chk(h_ack == e_ack, m_tag, "h_ack", 32'(h_ack), 32'(e_ack));
            chk(h_maperr == e_err, m_tag, "h_maperr", 32'(h_maperr), 32'(e_err));
            chk(s_req == e_req, m_tag, "s_req", 32'(s_req), 32'(e_req));
            if (e_req) begin
                chk(s_we == e_we, "R13", "s_we", 32'(s_we), 32'(e_we));
                chk(s_addr == e_addr, "R5", "s_addr", 32'(s_addr), 32'(e_addr));
                if (e_we)
                    chk(s_wdata == e_wd, "R7", "s_wdata", s_wdata, e_wd);
            end
            if (e_ack && e_rdchk)
                chk(h_rdata == e_rd, m_tag, "h_rdata", 32'(h_rdata), 32'(e_rd));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [15:0] g_rd;
    bit          g_err, g_ack;

    // One host access; waits up to limit cycles for the acknowledge.
    task automatic host(input bit we, input logic [17:0] a,
                        input logic [15:0] d, input int limit);
        @(negedge clk);
        h_stb = 1; h_we = we; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_stb = 0;
        g_ack = 0;
        for (int i = 0; i < limit && !g_ack; i++) begin
            if (h_ack) begin
                g_ack = 1; g_rd = h_rdata; g_err = h_maperr;
            end else @(negedge clk);
        end
    endtask

    localparam logic [17:0] PA3 = WLO + 3 * 1024 + 18'o24;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        chk(!h_ack && !s_req && !h_maperr, "R1", "idle after reset",
            {h_ack, s_req, h_maperr}, 0);
        chk(h_rdata == 0, "R1", "h_rdata reset", 32'(h_rdata), 0);
        rst_n = 1;
        host(0, TBL + 10, 0, 20);
        chk(g_ack && g_rd == 0, "R1", "entry 5 after reset", 32'(g_rd), 0);
        host(0, WLO, 0, 20);
        chk(g_ack && g_err, "R10", "unloaded entry refused", 32'(g_err), 1);
        // R2 R3: load entry 3 usable+writable, page 0x1234.
        host(1, TBL + 6, 16'hD234, 20);
        host(0, TBL + 6, 0, 20);
        chk(g_rd == 16'hD234, "R2", "entry readback", 32'(g_rd), 32'hD234);
        // R5 R6 R7: write pair lands at word 0x123405.
        host(1, PA3, 16'h1111, 20);
        chk(g_ack && !g_err, "R6", "low half ack", 32'(g_err), 0);
        host(1, PA3 + 2, 16'h2222, 40);
        chk(mem_rd(22'h123405) == 32'h22221111, "R7", "secondary word",
            mem_rd(22'h123405), 32'h22221111);
        // R8 R9: read back both halves.
        host(0, PA3, 0, 40);
        chk(g_rd == 16'h1111, "R8", "low half read", 32'(g_rd), 32'h1111);
        host(0, PA3 + 2, 0, 20);
        chk(g_rd == 16'h2222, "R9", "high half read", 32'(g_rd), 32'h2222);
        // R11: entry 4 read-only, page 0x42.
        host(1, TBL + 8, 16'h8042, 20);
        host(1, WLO + 4 * 1024 + 6, 16'hBEEF, 20);
        chk(g_ack && g_err, "R11", "write to read-only refused", 32'(g_err), 1);
        host(1, WLO + 4 * 1024 + 4, 16'hDEAD, 20);
        chk(g_err, "R11", "low write to read-only refused", 32'(g_err), 1);
        host(1, PA3 + 2, 16'h3333, 40);
        chk(mem_rd(22'h123405) == 32'h33331111, "R11", "buffer kept",
            mem_rd(22'h123405), 32'h33331111);
        host(0, WLO + 4 * 1024 + 4, 0, 40);
        chk(g_ack && !g_err, "R11", "read via read-only ok", 32'(g_err), 0);
        // R12: outside both regions.
        host(0, 18'o100000, 0, 6);
        chk(!g_ack, "R12", "no ack outside", 32'(g_ack), 0);
        // R4: window ends; top page last word.
        host(1, TBL + 30, 16'hC001, 20);
        host(0, 18'o177774, 0, 40);
        chk(g_rd == mem_rd(22'h0001FF) [15:0], "R4", "top of window",
            32'(g_rd), 32'(mem_rd(22'h0001FF) [15:0]));
        // Random traffic against the model.
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 10);
            logic [17:0] a;
            a = WLO + 18'($urandom % 16) * 1024 + 18'($urandom % 256) * 4;
            if (r < 2)
                host(1, TBL + 18'($urandom % 16) * 2,
                     {($urandom % 5) != 0, 1'($urandom), 14'($urandom)}, 20);
            else if (r == 2) host(0, TBL + 18'($urandom % 16) * 2, 0, 20);
            else if (r == 3) host(0, 18'($urandom % 18'o140000) & ~18'd1, 0, 6);
            else if (r < 7) begin
                if ($urandom % 4 != 0) host(1, a, 16'($urandom), 40);
                host(1, a + 2, 16'($urandom), 40);
            end else begin
                if ($urandom % 4 != 0) host(0, a, 0, 40);
                host(0, a + 2, 0, 40);
            end
        end
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule